// File: doc/BRIEF.md
# DRAM Refresh Timer and Strobe Sequencer

This block keeps DRAM contents alive by issuing CAS-before-RAS refresh cycles at a fixed, programmable interval. A free-running counter is compared against a programmable compare value. Each time the two are equal, a single compare-match flag is set and the counter restarts from zero. The interval is therefore the compare value plus one clock.

When refresh is enabled, the flag is a hardware trigger. The sequencer requests the bus and waits for a grant. It then drives CAS low, holds for a programmable number of wait cycles and drives RAS low for two cycles. Finally it releases both strobes in the same cycle. The flag is cleared by hardware at the moment the cycle is granted. A match that arrives while a cycle is running therefore leaves exactly one refresh pending.

When refresh is disabled, the same flag is an interval-timer status bit. Software clears it by reading it as 1 and then writing 0. The flag can raise an interrupt through an enable bit. That enable bit is held at zero whenever refresh is on.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: The flag is set at the clock edge where counter equals compare. At that same edge the counter returns to 0. After writing 0 to the counter with compare C, the flag first reads 1 exactly C+1 cycles later, and the counter then reads 0.
- R2: With refresh disabled, a control write carrying flag bit 0 clears the flag only if a read of the control register returned the flag as 1 beforehand. A write of 0 without that read leaves the flag set. A write of 1 leaves the flag set.
- R3: With refresh enabled, software writes of 0 to the flag are ignored, even after a read. The flag clears when the sequencer is granted the bus and drives CAS low.
- R4: The interrupt output is high exactly when the flag and the interrupt enable are both 1.
- R5: While refresh is enabled, the interrupt enable reads 0. Writing 1 to it, including in the same write that sets refresh enable, leaves it 0.
- R6: The 2-bit wait field W sets the CAS-to-RAS gap. RAS goes low W+1 cycles after CAS goes low, for W = 0, 1, 2 and 3. W is captured when the cycle is granted.
- R7: A refresh cycle first raises the bus request. CAS stays high until the grant is seen, then falls on the next cycle.
- R8: RAS stays low for exactly 2 cycles and CAS for W+3 cycles. Both strobes return high on the same cycle, and RAS is never low while CAS is high.
- R9: Both strobes are active-low. They are high, and the bus request is low, in reset and whenever no refresh cycle is in progress. After reset the flag, the enable, the wait field and refresh enable all read 0, and compare reads all ones.
- R10: A compare match during a running cycle causes exactly one more cycle. That cycle starts with CAS low after 2 cycles with both strobes high (given an immediate grant). Further matches before it starts are merged into it.
- R11: Register map on `reg_addr`: 0 is control, 1 is compare, 2 is counter (readable and writable). In the control register, bit 0 is the flag, bit 1 the interrupt enable, bits 3:2 the wait field and bit 4 refresh enable. Read data is combinational, and a read is registered at the clock edge where `reg_rd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms the software flag clear) |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the selected register |
| bus_gnt | input | 1 | Bus grant for a refresh cycle |
| bus_req | output | 1 | Bus request, high through the whole refresh cycle |
| cas_n | output | 1 | Column strobe, active-low |
| ras_n | output | 1 | Row strobe, active-low |
| irq | output | 1 | Compare-match interrupt request |

## Verification
The hardest case to reach is a compare match that lands inside a running refresh cycle, followed by a second match before the pending cycle begins. With a natural interval, that window is only a few cycles wide. The bench sets the compare value large and then writes the counter equal to it. This places a match exactly one cycle after the write. Two such writes are issued once CAS is seen low. A monitor on the strobe ports then counts CAS falling edges and measures the high gap before the last one.

// File: rtl/drf_pkg.sv
// Package: shared register map, control field positions and sequencer states
// for the DRAM refresh controller. Assumes data words of at least 5 bits.
package drf_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;

    localparam int BIT_FLAG = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_WLO  = 2;
    localparam int BIT_RFEN = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_CAS,
        ST_WAIT,
        ST_RAS
    } drf_state_e;

endpackage

// File: rtl/drf_interval_timer.sv
// Module: free-running interval counter with a compare register.
// Produces a one-cycle-wide match indication while counter equals compare;
// the counter restarts from zero on the following edge. Software writes to
// either register take priority over counting. Compare resets to all ones so
// that matches stay rare until software programs an interval.
module drf_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             match
);

    // Equality between the running count and the programmed compare value.
    always_comb begin
        match = (cnt_q == cmp_q);
    end

    // Counter: software load, wrap on match, otherwise increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (match) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Compare register: software loaded only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (cmp_wr) begin
            cmp_q <= wdata;
        end
    end

    // R1
    match_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !cnt_wr) |=> (cnt_q == '0));

endmodule

// File: rtl/drf_ctrl_regs.sv
// Module: control/status register with the dual-role compare-match flag.
// Refresh off: the flag clears by a read-as-1 then write-0 sequence.
// Refresh on: the flag clears when the sequencer starts a granted cycle, and
// the interrupt enable is held at zero. A new match always wins over a clear.
module drf_ctrl_regs #(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ctrl_rd,
    input  logic              wr_flag,
    input  logic              wr_ie,
    input  logic [WAIT_W-1:0] wr_wait,
    input  logic              wr_rfen,
    input  logic              match,
    input  logic              refresh_start,
    output logic              flag_q,
    output logic              ie_q,
    output logic [WAIT_W-1:0] wait_q,
    output logic              rfen_q,
    output logic              irq
);

    logic armed_q;
    logic sw_clr;
    logic flag_d;

    // Decide the next flag value: set beats any clear.
    always_comb begin
        sw_clr = ctrl_wr && !wr_flag && armed_q && !rfen_q;
        if (match) begin
            flag_d = 1'b1;
        end else if (sw_clr || refresh_start) begin
            flag_d = 1'b0;
        end else begin
            flag_d = flag_q;
        end
    end

    // Flag register and the read-as-1 arming bit for the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (!flag_d) begin
                armed_q <= 1'b0;
            end else if (ctrl_rd && flag_q) begin
                armed_q <= 1'b1;
            end
        end
    end

    // Configuration fields; enable is forced low whenever refresh is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            wait_q <= '0;
            rfen_q <= 1'b0;
        end else if (ctrl_wr) begin
            ie_q   <= wr_ie && !wr_rfen;
            wait_q <= wr_wait;
            rfen_q <= wr_rfen;
        end
    end

    // Interrupt request combines flag and enable.
    always_comb begin
        irq = flag_q && ie_q;
    end

    // R1
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag_q);

    // R5
    ie_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfen_q |-> !ie_q);

    // R2
    write_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && ctrl_wr && wr_flag && !refresh_start) |=> flag_q);

    // R3
    sw_clear_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && rfen_q && ctrl_wr && !refresh_start) |=> flag_q);

endmodule

// File: rtl/drf_strobe_seq.sv
// Module: CAS-before-RAS refresh sequencer.
// Requests the bus when triggered with refresh enabled, waits for grant, then
// runs CAS, WAIT (captured wait count) and RAS (RAS_CYC cycles) states before
// releasing both strobes together. Strobes decode from the state register.
module drf_strobe_seq #(
    parameter int WAIT_W  = 2,
    parameter int RAS_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rfen,
    input  logic              trigger,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic              cas_n,
    output logic              ras_n,
    output logic              refresh_start
);
    import drf_pkg::*;

    localparam int RAS_W  = $clog2(RAS_CYC + 1);
    localparam int STEP_W = (RAS_W > WAIT_W) ? RAS_W : WAIT_W;

    drf_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic [WAIT_W-1:0] wait_lat_q;

    // Grant acceptance pulse, used to clear the trigger flag.
    always_comb begin
        refresh_start = (state_q == ST_REQ) && bus_gnt;
    end

    // State walk with a shared down-counter for wait and RAS phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_q     <= '0;
            wait_lat_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (trigger && rfen) begin
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (bus_gnt) begin
                        state_q    <= ST_CAS;
                        wait_lat_q <= wait_cfg;
                    end
                end
                ST_CAS: begin
                    if (wait_lat_q == '0) begin
                        state_q <= ST_RAS;
                        step_q  <= STEP_W'(RAS_CYC - 1);
                    end else begin
                        state_q <= ST_WAIT;
                        step_q  <= STEP_W'(wait_lat_q) - STEP_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (step_q == '0) begin
                        state_q <= ST_RAS;
                        step_q  <= STEP_W'(RAS_CYC - 1);
                    end else begin
                        step_q <= step_q - STEP_W'(1);
                    end
                end
                ST_RAS: begin
                    if (step_q == '0) begin
                        state_q <= ST_IDLE;
                    end else begin
                        step_q <= step_q - STEP_W'(1);
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Strobe and request decode from the registered state.
    always_comb begin
        bus_req = (state_q != ST_IDLE);
        cas_n   = !((state_q == ST_CAS) || (state_q == ST_WAIT) || (state_q == ST_RAS));
        ras_n   = (state_q != ST_RAS);
    end

    // R8
    ras_under_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R8
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> $rose(ras_n));

    // R7
    cas_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ($past(bus_gnt) && $past(bus_req)));

    // R9
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (cas_n && ras_n));

endmodule

// File: rtl/dram_refresh_ctrl.sv
// Module: top of the DRAM refresh timer and sequencer.
// Decodes the register port, connects the interval timer, the control
// register and the strobe sequencer, and muxes read data combinationally.
module dram_refresh_ctrl #(
    parameter int CNT_W   = 16,
    parameter int WAIT_W  = 2,
    parameter int RAS_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic             cas_n,
    output logic             ras_n,
    output logic             irq
);
    import drf_pkg::*;

    logic              ctrl_wr, ctrl_rd, cmp_wr, cnt_wr;
    logic [CNT_W-1:0]  cnt_q, cmp_q;
    logic              match, refresh_start;
    logic              flag_q, ie_q, rfen_q;
    logic [WAIT_W-1:0] wait_q;

    // Register strobes per address.
    always_comb begin
        ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
        ctrl_rd = reg_rd && (reg_addr == ADDR_CTRL);
        cmp_wr  = reg_wr && (reg_addr == ADDR_CMP);
        cnt_wr  = reg_wr && (reg_addr == ADDR_CNT);
    end

    drf_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_wr (cnt_wr),
        .cmp_wr (cmp_wr),
        .wdata  (reg_wdata),
        .cnt_q  (cnt_q),
        .cmp_q  (cmp_q),
        .match  (match)
    );

    drf_ctrl_regs #(.WAIT_W(WAIT_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_wr       (ctrl_wr),
        .ctrl_rd       (ctrl_rd),
        .wr_flag       (reg_wdata[BIT_FLAG]),
        .wr_ie         (reg_wdata[BIT_IE]),
        .wr_wait       (reg_wdata[BIT_WLO +: WAIT_W]),
        .wr_rfen       (reg_wdata[BIT_RFEN]),
        .match         (match),
        .refresh_start (refresh_start),
        .flag_q        (flag_q),
        .ie_q          (ie_q),
        .wait_q        (wait_q),
        .rfen_q        (rfen_q),
        .irq           (irq)
    );

    drf_strobe_seq #(.WAIT_W(WAIT_W), .RAS_CYC(RAS_CYC)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .rfen          (rfen_q),
        .trigger       (flag_q),
        .wait_cfg      (wait_q),
        .bus_gnt       (bus_gnt),
        .bus_req       (bus_req),
        .cas_n         (cas_n),
        .ras_n         (ras_n),
        .refresh_start (refresh_start)
    );

    // Read data mux over the register map.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[BIT_FLAG]            = flag_q;
                reg_rdata[BIT_IE]              = ie_q;
                reg_rdata[BIT_WLO +: WAIT_W]   = wait_q;
                reg_rdata[BIT_RFEN]            = rfen_q;
            end
            ADDR_CMP: reg_rdata = cmp_q;
            ADDR_CNT: reg_rdata = cnt_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/dram_refresh_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module dram_refresh_ctrl_bench;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;
    logic          bus_gnt = 1'b0;
    logic          bus_req, cas_n, ras_n, irq;

    int checks = 0;
    int failures = 0;
    int cas_falls = 0;
    int hi_run = 0;
    int last_gap = 0;
    logic prev_cas = 1'b1;

    always #10 clk = ~clk;

    dram_refresh_ctrl #(.CNT_W(CW)) u_dram_refresh_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_gnt(bus_gnt), .bus_req(bus_req), .cas_n(cas_n), .ras_n(ras_n),
        .irq(irq)
    );

    // Port monitor: CAS falling edges and the high run before each.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cas && !cas_n) begin
                cas_falls = cas_falls + 1;
                last_gap  = hi_run;
            end
            hi_run   = cas_n ? hi_run + 1 : 0;
            prev_cas = cas_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [CW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [CW-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [CW-1:0] v;
        check(cas_n && ras_n, "R9 strobes high after reset", {cas_n, ras_n}, 3);
        check(!bus_req && !irq, "R9 req/irq low after reset", {bus_req, irq}, 0);
        peek(2'd0, v);
        check(v == 0, "R9 control resets to 0", v, 0);
        peek(2'd1, v);
        check(v == 16'hFFFF, "R9 compare resets to ones", v, 16'hFFFF);
    endtask

    task automatic t_timer();
        logic [CW-1:0] v;
        int n = 0;
        int busy = 0;
        wr_reg(2'd1, 16'd9);
        wr_reg(2'd2, 16'd0);
        for (int i = 0; i < 50; i++) begin
            peek(2'd0, v);
            if (v[0]) break;
            if (bus_req || !cas_n) busy++;
            @(negedge clk);
            n++;
        end
        check(n == 10, "R1 interval C+1", n, 10);
        peek(2'd2, v);
        check(v == 0, "R1 counter wraps to 0", v, 0);
        check(busy == 0, "R9 no refresh while disabled", busy, 0);
        wr_reg(2'd1, 16'd1000);
    endtask

    task automatic t_clear();
        logic [CW-1:0] v;
        wr_reg(2'd0, 16'h0000);
        peek(2'd0, v);
        check(v[0] == 1'b1, "R2 write 0 without read ignored", v[0], 1);
        rd_reg(2'd0, v);
        wr_reg(2'd0, 16'h0001);
        peek(2'd0, v);
        check(v[0] == 1'b1, "R2 write 1 ignored", v[0], 1);
        rd_reg(2'd0, v);
        wr_reg(2'd0, 16'h0000);
        peek(2'd0, v);
        check(v[0] == 1'b0, "R2 read then write 0 clears", v[0], 0);
    endtask

    task automatic t_irq();
        logic [CW-1:0] v;
        wr_reg(2'd0, 16'h0002);
        check(irq == 1'b0, "R4 irq low with flag 0", irq, 0);
        wr_reg(2'd2, 16'd1000);
        @(negedge clk);
        check(irq == 1'b1, "R4 irq with flag and enable", irq, 1);
        wr_reg(2'd0, 16'h0001);
        check(irq == 1'b0, "R4 irq low with enable 0", irq, 0);
        rd_reg(2'd0, v);
        wr_reg(2'd0, 16'h0000);
        peek(2'd0, v);
        check(v[0] == 1'b0, "R2 flag cleared before lock test", v[0], 0);
    endtask

    task automatic t_lock();
        logic [CW-1:0] v;
        wr_reg(2'd0, 16'h0012);
        peek(2'd0, v);
        check(v[1] == 1'b0, "R5 enable forced 0 on same write", v[1], 0);
        check(v[4] == 1'b1, "R11 refresh enable bit 4", v[4], 1);
        wr_reg(2'd0, 16'h0012);
        peek(2'd0, v);
        check(v[1] == 1'b0, "R5 enable write ignored", v[1], 0);
    endtask

    task automatic t_hwclr();
        logic [CW-1:0] v;
        int hi = 0;
        wr_reg(2'd2, 16'd1000);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (cas_n) hi++;
        end
        check(bus_req == 1'b1, "R7 request raised before grant", bus_req, 1);
        check(hi == 6, "R7 CAS held high without grant", hi, 6);
        rd_reg(2'd0, v);
        wr_reg(2'd0, 16'h0010);
        peek(2'd0, v);
        check(v[0] == 1'b1, "R3 software clear ignored in refresh", v[0], 1);
        @(negedge clk);
        bus_gnt = 1'b1;
        @(negedge clk);
        check(cas_n == 1'b0, "R7 CAS low one cycle after grant", cas_n, 0);
        peek(2'd0, v);
        check(v[0] == 1'b0, "R3 flag cleared by refresh", v[0], 0);
        repeat (10) @(negedge clk);
        check(!bus_req && cas_n && ras_n, "R9 idle after cycle", {bus_req, cas_n, ras_n}, 3);
    endtask

    task automatic t_seq(input int w);
        int cf = -1, rf = -1, cl = 0, rl = 0, rise = -1;
        bit together = 1'b0;
        int f0;
        wr_reg(2'd0, 16'(16'h0010 | (w << 2)));
        f0 = cas_falls;
        wr_reg(2'd2, 16'd1000);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!cas_n) begin cl++; if (cf < 0) cf = i; end
            if (!ras_n) begin rl++; if (rf < 0) rf = i; end
            if (cf >= 0 && cas_n && rise < 0) begin
                rise = i;
                together = ras_n;
            end
        end
        check(rf - cf == w + 1, "R6 CAS-to-RAS gap", rf - cf, w + 1);
        check(rl == 2, "R8 RAS width", rl, 2);
        check(cl == w + 3, "R8 CAS width", cl, w + 3);
        check(together && rise - rf == 2, "R8 strobes release together", rise - rf, 2);
        check(cas_falls - f0 == 1, "R8 single cycle per match", cas_falls - f0, 1);
    endtask

    task automatic t_pending();
        int f0;
        wr_reg(2'd0, 16'h001C);
        f0 = cas_falls;
        wr_reg(2'd2, 16'd1000);
        for (int i = 0; i < 20; i++) begin
            if (!cas_n) break;
            @(negedge clk);
        end
        wr_reg(2'd2, 16'd1000);
        wr_reg(2'd2, 16'd1000);
        repeat (40) @(negedge clk);
        check(cas_falls - f0 == 2, "R10 one pending cycle, extras merged", cas_falls - f0, 2);
        check(last_gap == 2, "R10 pending cycle gap", last_gap, 2);
    endtask

    initial begin
        #(20 * 190000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timer();
        t_clear();
        t_irq();
        t_lock();
        t_hwclr();
        for (int w = 0; w < 4; w++) t_seq(w);
        t_pending();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule